// File: doc/BRIEF.md
# Mirrored Register Poll Resynchronizer

This block is a host-side register page that holds a local image of a bank of registers on a remote line-side device. A host write to a mirrored address updates the local image at once and also queues a write toward the remote side, so both copies stay equal while the link behaves. Because the link can corrupt data, the page also has a poll engine. Software uses it to ask whether one remote entry still agrees with its local image.

To poll, software writes a 4-bit remote index into the poll control register with the command bit set. The block records a snapshot of the local image entry and queues a read of the remote entry behind any writes already waiting. When the response arrives, the block clears the command bit, sets or clears the agreement flag, and stores the fetched byte in a read-only readback register. If no response arrives within a bounded number of cycles, the poll ends with the flag clear. Recovery is up to software.

The remote link is a plain request/response port. It carries one transaction at a time, and requests leave in the order the host caused them.

Top module: `mirror_poll_resync`

## Requirements
- R1: After reset, each mirrored index i (2 to 8 and 10 to 14, at address 0x10+i) reads ((i*17) XOR 0x5A) mod 256. The poll control register (0x19), the readback register (0x1F) and every other address read 0x00, and no remote request is pending.
- R2: A host write to a mirrored address 0x10+i is readable from the following cycle. It also produces one remote request with req_write=1, req_index=i and req_wdata equal to the written byte.
- R3: Remote requests go out one at a time, in the order the host caused them. While req_valid is high and req_ready is low, req_valid, req_write, req_index and req_wdata stay unchanged.
- R4: The poll control register reads {POLL(bit 7), MATCH(bit 6), 2'b00, INDEX(bits 3:0)}. While POLL=0, a write with bit 7 = 0 changes only INDEX.
- R5: While POLL=0, a write to 0x19 with bit 7 = 1 sets POLL, latches INDEX and snapshots the local entry. It queues exactly one remote read behind the writes already queued. While POLL=1, any write to 0x19 is ignored and starts no further read.
- R6: MATCH cannot be changed by a host write.
- R7: A response (rsp_valid high while a poll read is outstanding) updates the block at that same clock edge. POLL clears, 0x1F takes rsp_data, and MATCH is set when INDEX is mirrored and rsp_data equals the snapshot.
- R8: MATCH is cleared when the fetched byte differs from the snapshot or INDEX is not mirrored. Host writes made after the poll started do not affect the comparison.
- R9: If no response arrives, the poll ends at the TIMEOUT-th clock edge after the read request was accepted. POLL and MATCH clear, and 0x1F keeps its previous value.
- R10: Writes to 0x1F are ignored. Writes to 0x19 and to unmirrored addresses never produce a remote write.
- R11: rsp_valid is ignored when no poll read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| req_valid | output | 1 | Remote request pending |
| req_ready | input | 1 | Remote side accepts the request |
| req_write | output | 1 | 1 = forwarded write, 0 = poll read |
| req_index | output | 4 | Remote register index |
| req_wdata | output | 8 | Forwarded write data |
| rsp_valid | input | 1 | Remote read response strobe |
| rsp_data | input | 8 | Remote read response data |

## Verification
A mirrored write is visible on host_rdata in the cycle after its write edge. Its request can be accepted no earlier than the next edge. A response changes the poll and readback registers at the edge where rsp_valid is sampled, and a timeout lands exactly TIMEOUT edges after the read was accepted. The bench drives and reads one time unit after each falling edge. It uses a posedge counter to find the accepting edge of a poll read, then checks that POLL is still set one edge before the deadline and clear one edge after it. The remote model matches each accepted write against an in-order queue of expected writes, so ordering and stray forwards are checked at the moment they happen.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
    localparam int DW          = 8;
    localparam int IW          = 4;
    localparam int NREG        = 1 << IW;
    localparam int PAD         = DW - 2 - IW;
    localparam int POLL_N      = 9;
    localparam int RDBK_N      = 15;
    localparam int MIR_FIRST   = 2;
    localparam int MIR_LAST    = 14;
    localparam int POLL_BIT    = 7;
    localparam logic [IW-1:0] PAGE    = 4'h1;
    localparam logic [IW-1:0] IDX_POLL = IW'(POLL_N);
    localparam logic [IW-1:0] IDX_RDBK = IW'(RDBK_N);

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic          wr;
        logic [IW-1:0] idx;
        byte_t         data;
    } lreq_t;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_WAIT = 1'b1
    } lk_state_e;

    function automatic logic is_mirrored(input int unsigned i);
        return (i >= MIR_FIRST) && (i <= MIR_LAST) && (i != POLL_N);
    endfunction

    function automatic byte_t reg_default(input int unsigned i);
        byte_t v;
        v = byte_t'(i * 17);
        return v ^ byte_t'(8'h5A);
    endfunction
endpackage

// File: rtl/mrp_shadow_bank.sv
module mrp_shadow_bank
    import mrp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  byte_t                wr_data,
    output byte_t [NREG-1:0]     image
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (is_mirrored(g)) begin : g_live
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reg_default(g);
                else if (wr_en && wr_idx == IW'(g))
                    q <= wr_data;
            end
            assign image[g] = q;
        end else begin : g_tied
            assign image[g] = '0;
        end
    end
endmodule

// File: rtl/mrp_req_fifo.sv
module mrp_req_fifo
    import mrp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  lreq_t push_data,
    input  logic  pop,
    output lreq_t head,
    output logic  empty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    lreq_t         mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    // R3: requests are kept in order; none may be lost to a full queue
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
endmodule

// File: rtl/mrp_link.sv
module mrp_link
    import mrp_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  lreq_t         head,
    input  logic          empty,
    output logic          pop,
    output logic          req_valid,
    input  logic          req_ready,
    output logic          req_write,
    output logic [IW-1:0] req_index,
    output byte_t         req_wdata,
    input  logic          rsp_valid,
    output logic          done_ok,
    output logic          done_late
);
    localparam int TW = $clog2(TIMEOUT + 1);

    lk_state_e     st;
    logic [TW-1:0] wcnt;

    assign req_valid = (st == LK_IDLE) && !empty;
    assign req_write = head.wr;
    assign req_index = head.idx;
    assign req_wdata = head.data;
    assign pop       = req_valid && req_ready;
    assign done_ok   = (st == LK_WAIT) && rsp_valid;
    assign done_late = (st == LK_WAIT) && !rsp_valid && (wcnt == TW'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LK_IDLE;
            wcnt <= '0;
        end else begin
            case (st)
                LK_IDLE: begin
                    if (pop && !head.wr) begin
                        st   <= LK_WAIT;
                        wcnt <= '0;
                    end
                end
                LK_WAIT: begin
                    if (done_ok || done_late)
                        st <= LK_IDLE;
                    else
                        wcnt <= wcnt + 1'b1;
                end
                default: st <= LK_IDLE;
            endcase
        end
    end

    // R3: an offered request stays put until taken
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_write)
                                    && $stable(req_index) && $stable(req_wdata));
endmodule

// File: rtl/mirror_poll_resync.sv
module mirror_poll_resync
    import mrp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int TIMEOUT    = 64,
    parameter int AW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          req_valid,
    input  logic          req_ready,
    output logic          req_write,
    output logic [IW-1:0] req_index,
    output logic [DW-1:0] req_wdata,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data
);
    byte_t [NREG-1:0] image;
    logic             in_page, mir_wr, poll_wr, poll_start, push;
    logic [IW-1:0]    nib;
    lreq_t            push_data, head;
    logic             empty, full, pop, done_ok, done_late;

    logic             poll_q, match_q;
    logic [IW-1:0]    poll_idx;
    byte_t            snap, rdbk;

    assign in_page    = host_addr[AW-1:IW] == (AW-IW)'(PAGE);
    assign nib        = host_addr[IW-1:0];
    assign mir_wr     = host_wr && in_page && is_mirrored(32'(nib));
    assign poll_wr    = host_wr && in_page && (nib == IDX_POLL);
    assign poll_start = poll_wr && !poll_q && host_wdata[POLL_BIT];
    assign push       = mir_wr || poll_start;

    always_comb begin
        push_data.wr   = mir_wr;
        push_data.idx  = mir_wr ? nib : host_wdata[IW-1:0];
        push_data.data = mir_wr ? host_wdata : '0;
    end

    mrp_shadow_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mir_wr),
        .wr_idx  (nib),
        .wr_data (host_wdata),
        .image   (image)
    );

    mrp_req_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    mrp_link #(.TIMEOUT(TIMEOUT)) u_link (
        .clk       (clk),
        .rst       (rst),
        .head      (head),
        .empty     (empty),
        .pop       (pop),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_index (req_index),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .done_ok   (done_ok),
        .done_late (done_late)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_q   <= 1'b0;
            match_q  <= 1'b0;
            poll_idx <= '0;
            snap     <= '0;
            rdbk     <= '0;
        end else if (done_ok) begin
            poll_q  <= 1'b0;
            match_q <= is_mirrored(32'(poll_idx)) && (rsp_data == snap);
            rdbk    <= rsp_data;
        end else if (done_late) begin
            poll_q  <= 1'b0;
            match_q <= 1'b0;
        end else if (poll_wr && !poll_q) begin
            poll_idx <= host_wdata[IW-1:0];
            if (host_wdata[POLL_BIT]) begin
                poll_q <= 1'b1;
                snap   <= image[host_wdata[IW-1:0]];
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (in_page) begin
            if (nib == IDX_POLL)
                host_rdata = {poll_q, match_q, {PAD{1'b0}}, poll_idx};
            else if (nib == IDX_RDBK)
                host_rdata = rdbk;
            else
                host_rdata = image[nib];
        end
    end

    // R7: a response ends the poll and lands in the readback register
    p_poll_clear_r7: assert property (@(posedge clk) disable iff (rst)
        done_ok |=> !poll_q && (rdbk == $past(rsp_data)));

    // R9: an expired wait ends the poll with no agreement and no readback change
    p_timeout_r9: assert property (@(posedge clk) disable iff (rst)
        done_late |=> !poll_q && !match_q && $stable(rdbk));

    // R5: the control register is frozen while a poll runs
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (rst)
        poll_q && poll_wr |=> $stable(poll_idx));

    // R6: host writes never move the agreement flag
    p_match_ro_r6: assert property (@(posedge clk) disable iff (rst)
        poll_wr && !done_ok && !done_late |=> $stable(match_q));
endmodule

// File: tb/mirror_poll_resync_test.sv
module mirror_poll_resync_test;
    localparam int TO    = 40;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr;
    logic [7:0] host_addr, host_wdata, host_rdata;
    logic       req_valid, req_ready, req_write;
    logic [3:0] req_index;
    logic [7:0] req_wdata;
    logic       rsp_valid;
    logic [7:0] rsp_data;

    always #10 clk = ~clk;

    mirror_poll_resync #(.FIFO_DEPTH(DEPTH), .TIMEOUT(TO), .AW(8)) uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    int nchk = 0, nfail = 0;
    int cyc = 0;
    logic [7:0] rem [16];
    logic [7:0] sh  [16];
    logic [3:0] eq_idx [1024];
    logic [7:0] eq_dat [1024];
    int eq_wr = 0, eq_rd = 0;
    int rsp_cnt = 0, reads_seen = 0, hs_cyc = 0;
    logic [7:0] rsp_val;
    bit drop = 0, inj = 0, rd_hs = 0, finished = 0;

    function automatic logic [7:0] exp_def(input int i);
        return 8'((i * 17) ^ 90);
    endfunction

    function automatic bit exp_mir(input int i);
        return (i >= 2 && i <= 14 && i != 9);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // remote side model, acting only on falling edges
    always @(negedge clk) begin
        if (rst) begin
            req_ready = 1'b0;
            rsp_valid = 1'b0;
            rsp_data  = 8'h00;
            rsp_cnt   = 0;
        end else begin
            rsp_valid = 1'b0;
            if (inj) begin
                rsp_valid = 1'b1;
                rsp_data  = 8'hEE;
                inj = 0;
            end
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0 && !drop) begin
                    rsp_valid = 1'b1;
                    rsp_data  = rsp_val;
                end
            end
            req_ready = ($urandom_range(3) != 0);
            if (req_valid && req_ready) begin
                if (req_write) begin
                    if (eq_rd < eq_wr) begin
                        check("R3 forwarded index order", {4'h0, req_index}, {4'h0, eq_idx[eq_rd]});
                        check("R2 forwarded data", req_wdata, eq_dat[eq_rd]);
                        eq_rd++;
                    end else begin
                        nchk++; nfail++;
                        $display("FAIL R10 stray forwarded write: got idx %h data %h expected none",
                                 req_index, req_wdata);
                    end
                    rem[req_index] = req_wdata;
                end else begin
                    reads_seen++;
                    rd_hs   = 1;
                    hs_cyc  = cyc;
                    rsp_cnt = 1 + $urandom_range(4);
                    rsp_val = rem[req_index];
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); #1;
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic sh_wr(input int i, input logic [7:0] d);
        eq_idx[eq_wr] = 4'(i);
        eq_dat[eq_wr] = d;
        eq_wr++;
        sh[i] = d;
        wr(8'h10 | 8'(i), d);
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && eq_rd < eq_wr; k++) @(negedge clk);
        check("R3 queue drained", 8'(eq_wr - eq_rd), 8'h00);
    endtask

    task automatic wait_idle(output logic [7:0] v);
        for (int k = 0; k < TO + 40; k++) begin
            rd(8'h19, v);
            if (!v[7]) break;
        end
    endtask

    task automatic poll(input int i, output logic [7:0] v);
        wr(8'h19, 8'h80 | 8'(i));
        wait_idle(v);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got no completion expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v, prev, exp_rb;
        bit corrupt;
        int i, op;
        void'($urandom(5));
        host_wr = 0; host_addr = 0; host_wdata = 0;
        for (int k = 0; k < 16; k++) begin
            rem[k] = exp_def(k);
            sh[k]  = exp_mir(k) ? exp_def(k) : 8'h00;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset image and idle link
        check("R1 no request after reset", {7'h0, req_valid}, 8'h00);
        for (int a = 16; a < 32; a++) begin
            rd(8'(a), v);
            check("R1 reset value", v, exp_mir(a - 16) ? exp_def(a - 16) : 8'h00);
        end
        rd(8'h02, v);
        check("R1 off-page address reads zero", v, 8'h00);

        // R2 local update and forward
        sh_wr(3, 8'hC3);
        rd(8'h13, v);
        check("R2 local copy", v, 8'hC3);
        drain();
        check("R2 remote copy", rem[3], 8'hC3);

        // R3 ordering of back-to-back writes
        sh_wr(4, 8'h11);
        sh_wr(4, 8'h22);
        sh_wr(7, 8'h33);
        drain();
        check("R3 last write wins", rem[4], 8'h22);
        check("R3 later write", rem[7], 8'h33);

        // R4 index-only write and reserved bits
        wr(8'h19, 8'h3A);
        rd(8'h19, v);
        check("R4 index only write", v, 8'h0A);

        // R7 matching poll
        poll(3, v);
        check("R7 poll done with match", v, 8'h43);
        rd(8'h1F, v);
        check("R7 readback", v, 8'hC3);

        // R6 MATCH not writable
        wr(8'h19, 8'h05);
        rd(8'h19, v);
        check("R6 match kept", v, 8'h45);

        // R8 mismatch after remote corruption
        rem[6] = rem[6] ^ 8'hFF;
        poll(6, v);
        check("R8 mismatch flag", v, 8'h06);
        rd(8'h1F, v);
        check("R8 fetched corrupt value", v, exp_def(6) ^ 8'hFF);
        sh_wr(6, 8'h66);
        drain();

        // R8 snapshot: write after poll start does not disturb compare
        wr(8'h19, 8'h85);
        sh_wr(5, 8'h5F);
        wait_idle(v);
        check("R8 snapshot compare", v, 8'h45);
        rd(8'h1F, v);
        check("R8 old remote value", v, exp_def(5));
        rd(8'h15, v);
        check("R8 local holds new", v, 8'h5F);
        drain();

        // R8 unmirrored index
        poll(9, v);
        check("R8 unmirrored index", v, 8'h09);
        rd(8'h1F, v);
        check("R8 unmirrored readback", v, exp_def(9));
        poll(0, v);
        check("R8 index zero", v, 8'h00);

        // R10 readback write ignored, nothing forwarded
        rd(8'h1F, prev);
        wr(8'h1F, 8'h77);
        wr(8'h11, 8'h99);
        rd(8'h1F, v);
        check("R10 readback read-only", v, prev);
        rd(8'h11, v);
        check("R10 unmirrored write dropped", v, 8'h00);
        repeat (10) @(negedge clk);

        // R11 stray response
        inj = 1;
        repeat (4) @(negedge clk);
        rd(8'h19, v);
        check("R11 poll reg untouched", v, 8'h00);
        rd(8'h1F, v);
        check("R11 readback untouched", v, prev);

        // R5 and R9: busy write ignored, timeout edge exact
        drop = 1;
        rd_hs = 0;
        i = reads_seen;
        wr(8'h19, 8'h83);
        for (int k = 0; k < 50 && !rd_hs; k++) @(negedge clk);
        wr(8'h19, 8'h87);
        rd(8'h19, v);
        check("R5 busy write ignored", v, 8'h83);
        while (cyc < hs_cyc + TO) @(negedge clk);
        #2 host_addr = 8'h19;
        #1 check("R9 still busy one edge early", host_rdata, 8'h83);
        while (cyc < hs_cyc + TO + 1) @(negedge clk);
        #2 host_addr = 8'h19;
        #1 check("R9 timeout ends poll", host_rdata, 8'h03);
        rd(8'h1F, v);
        check("R9 readback kept", v, prev);
        check("R5 single read issued", 8'(reads_seen - i), 8'h01);
        drop = 0;
        repeat (8) @(negedge clk);

        // random mix
        for (int it = 0; it < 150; it++) begin
            op = $urandom_range(2);
            if (op < 2) begin
                do i = $urandom_range(15); while (!exp_mir(i));
                sh_wr(i, 8'($urandom));
                rd(8'h10 | 8'(i), v);
                check("R2 random local write", v, sh[i]);
            end else begin
                i = $urandom_range(15);
                drain();
                corrupt = exp_mir(i) && ($urandom_range(3) == 0);
                if (corrupt) rem[i] = rem[i] ^ 8'(1 + $urandom_range(254));
                exp_rb = rem[i];
                poll(i, v);
                check("R7 random poll result", v,
                      {1'b0, exp_mir(i) && (exp_rb == sh[i]), 2'b00, 4'(i)});
                rd(8'h1F, v);
                check("R7 random readback", v, exp_rb);
                if (corrupt) sh_wr(i, sh[i]);
            end
        end
        drain();

        finished = 1;
        summary();
        $finish;
    end
endmodule